// File: doc/BRIEF.md
# Output Divider Synchronization Controller

This block lines up a bank of output clock dividers with a chosen timing event. A primary sync request is formed as the OR of a software control bit and three hardware request lines. A 2-bit mode input then decides what the request does. In direct mode the request itself holds the dividers, and its falling edge lets them go. In the two armed modes a rising request arms an edge detector, which holds the dividers until the first rising edge of a selected event arrives. That event is either the active input reference or the feedback rollover pulse of a phase accumulator.

The block runs on the output-divider clock. Requests and events are treated as asynchronous, so each one passes through a multi-flop synchronizer. The release then travels down a short fixed pipeline. As a result, the dividers restart a known number of clock edges after the edge that first samples the trigger.

All dividers restart from zero on the same clock edge, so their outputs come out aligned. A status output shows whether the detector is holding, and a second output shows the stall that the dividers actually see.

Top module: `odsync_ctrl`

## Requirements
- R1: `mode_sel` selects the sync mode. 2'b00 is direct, 2'b01 waits for the reference event, 2'b10 waits for the feedback rollover event, and 2'b11 behaves exactly as direct.
- R2: The primary request is the OR of `sw_sync` and `hw_req[2:0]`. In direct mode, any one of these inputs raised alone stalls the dividers.
- R3: In direct mode the stall is held while the primary request is high, and the falling edge of the primary request releases the dividers.
- R4: The software bit acts as a sync event when it is cleared (1 to 0). Its clearing releases the dividers in direct mode.
- R5: In modes 01 and 10, a rising primary request arms the detector, and `sync_busy` and `div_stall` go high. A later fall of the primary request does not release the dividers.
- R6: While the detector is armed, the first rising edge of the selected event (`ref_edge` in mode 01, `fb_roll` in mode 10) releases it. An edge on the other event input has no effect.
- R7: While the detector is armed, further primary request edges are ignored. After it fires, a primary request that stays high does not re-arm it; only a new rising edge does.
- R8: Let edge k be the clock edge that first samples an input change. `sync_busy` follows the change at edge k+2, and `div_stall` follows at edge k+3. Because the asynchronous edge can fall anywhere within one clock period, the first counting edge comes 4 or 5 clock periods after that edge.
- R9: While `div_stall` is high, every `clk_out` bit is low and its counter is held at zero. After `div_stall` falls, output i stays low and rises exactly N_i edges later, where N_i is byte i of `div_ratio`.
- R10: Asserting `rst_n` clears `sync_busy` and `div_stall` at once and disarms the detector. After reset, an event edge with no arming request has no effect.
- R11: `sync_busy` is the status of the detector: it is high while a direct request holds the dividers or while the detector is armed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Output-divider clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously and released synchronously |
| mode_sel | input | 2 | Sync mode (see R1) |
| sw_sync | input | 1 | Software sync control bit |
| hw_req | input | 3 | Hardware sync request lines |
| ref_edge | input | 1 | Active input reference event (asynchronous) |
| fb_roll | input | 1 | Feedback rollover event (asynchronous) |
| div_ratio | input | NUM_OUT*CNT_W | Division ratio per output; values below 2 are treated as 2 |
| clk_out | output | NUM_OUT | Divided output clocks |
| div_stall | output | 1 | Stall applied to the dividers |
| sync_busy | output | 1 | Detector status |

## Verification
A detector that stays wrong, for example left armed, armed without a request, or sensitive to the wrong event, shows at the ports as early as two edges after the sampled input: `sync_busy` sits at the wrong level, and `div_stall` shows the same error one edge later. A restart pipeline that is too long or too short shifts the fall of `div_stall`, and with it the first rising edge of every output, by whole cycles. The bench pins these points to exact cycle numbers. Counters that are not cleared, or that restart on different edges, show within one divider period as output edges that are out of place or out of step with each other.

// File: rtl/odsync_pkg.sv
package odsync_pkg;
  typedef enum logic [1:0] {
    SYNC_DIRECT = 2'b00,
    SYNC_REF    = 2'b01,
    SYNC_FB     = 2'b10,
    SYNC_RSVD   = 2'b11
  } sync_mode_e;
endpackage

// File: rtl/odsync_bitsync.sv
module odsync_bitsync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/odsync_arm_detect.sv
module odsync_arm_detect
  import odsync_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       prim_s,
  input  logic       ref_s,
  input  logic       fb_s,
  output logic       busy_o,
  output logic       rel_o
);
  logic prim_q, evt_q, det_q;
  logic prim_rise, evt_s, evt_rise, armed_mode, det_d;

  always_comb begin
    armed_mode = (mode == SYNC_REF) || (mode == SYNC_FB);
    evt_s      = (mode == SYNC_FB) ? fb_s : ref_s;
    prim_rise  = prim_s & ~prim_q;
    evt_rise   = evt_s & ~evt_q;
    if (armed_mode) begin
      if (det_q) det_d = ~evt_rise;
      else       det_d = prim_rise;
    end else begin
      det_d = prim_s;
    end
    rel_o = det_q & ~det_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prim_q <= 1'b0;
      evt_q  <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prim_q <= prim_s;
      evt_q  <= evt_s;
      det_q  <= det_d;
    end
  end

  assign busy_o = det_q;

  // R5
  arm_on_primary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_mode && $stable(mode) && $rose(det_q)) |-> prim_q);

  // R6
  fire_on_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_mode && $stable(mode) && $fell(det_q)) |-> evt_q);
endmodule

// File: rtl/odsync_release_pipe.sv
module odsync_release_pipe #(
  parameter int PIPE_STAGES = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy_i,
  input  logic rel_i,
  output logic hold_o
);
  logic [PIPE_STAGES-1:0] rel_sr_q, rel_sr_d;
  logic hold_q, hold_d;

  generate
    if (PIPE_STAGES == 1) begin : g_one
      assign rel_sr_d = rel_i;
    end else begin : g_many
      assign rel_sr_d = {rel_sr_q[PIPE_STAGES-2:0], rel_i};
    end
  endgenerate

  always_comb begin
    hold_d = busy_i | (hold_q & ~rel_sr_q[PIPE_STAGES-1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rel_sr_q <= '0;
      hold_q   <= 1'b0;
    end else begin
      rel_sr_q <= rel_sr_d;
      hold_q   <= hold_d;
    end
  end

  assign hold_o = hold_q;

  // R8
  release_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hold_q) |-> !busy_i);
endmodule

// File: rtl/odsync_divider.sv
module odsync_divider #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic [CNT_W-1:0] ratio_i,
  output logic             clk_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt_q, cnt_d, eff, last, half;
  logic started_q, started_d, wrap;

  always_comb begin
    eff       = (ratio_i < TWO) ? TWO : ratio_i;
    last      = eff - ONE;
    half      = eff >> 1;
    wrap      = (cnt_q == last);
    if (hold_i) begin
      cnt_d     = '0;
      started_d = 1'b0;
    end else begin
      cnt_d     = wrap ? '0 : cnt_q + ONE;
      started_d = started_q | wrap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      started_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      started_q <= started_d;
    end
  end

  assign clk_o = started_q & ~hold_i & (cnt_q < half);

  // R9
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && $past(hold_i)) |-> (cnt_q == '0 && !started_q));
endmodule

// File: rtl/odsync_ctrl.sv
module odsync_ctrl #(
  parameter int NUM_OUT     = 3,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int PIPE_STAGES = 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               mode_sel,
  input  logic                     sw_sync,
  input  logic [2:0]               hw_req,
  input  logic                     ref_edge,
  input  logic                     fb_roll,
  input  logic [NUM_OUT*CNT_W-1:0] div_ratio,
  output logic [NUM_OUT-1:0]       clk_out,
  output logic                     div_stall,
  output logic                     sync_busy
);
  localparam int REQ_W = 6;

  logic             rst_q;
  logic [REQ_W-1:0] req_raw, req_s;
  logic             prim_s, rel_pulse, busy, hold;

  odsync_bitsync #(.STAGES(2), .WIDTH(1)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_q)
  );

  assign req_raw = {fb_roll, ref_edge, hw_req, sw_sync};

  odsync_bitsync #(.STAGES(SYNC_STAGES), .WIDTH(REQ_W)) u_in_sync (
    .clk(clk), .rst_n(rst_q), .d(req_raw), .q(req_s)
  );

  assign prim_s = |req_s[3:0];

  odsync_arm_detect u_det (
    .clk(clk), .rst_n(rst_q), .mode(mode_sel), .prim_s(prim_s),
    .ref_s(req_s[4]), .fb_s(req_s[5]), .busy_o(busy), .rel_o(rel_pulse)
  );

  odsync_release_pipe #(.PIPE_STAGES(PIPE_STAGES)) u_pipe (
    .clk(clk), .rst_n(rst_q), .busy_i(busy), .rel_i(rel_pulse), .hold_o(hold)
  );

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_div
      odsync_divider #(.CNT_W(CNT_W)) u_div (
        .clk(clk), .rst_n(rst_q), .hold_i(hold),
        .ratio_i(div_ratio[g*CNT_W +: CNT_W]), .clk_o(clk_out[g])
      );
    end
  endgenerate

  assign div_stall = hold;
  assign sync_busy = busy;

  // R9
  stall_outs_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    div_stall |-> (clk_out == '0));

  // R8
  busy_to_stall_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(sync_busy) |=> div_stall);
endmodule

// File: tb/odsync_ctrl_tb.sv
module odsync_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_OUT = 3;
  localparam int CNT_W = 8;

  typedef struct {
    int    cyc;
    int    sig;
    logic  val;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode_sel;
  logic sw_sync, ref_edge, fb_roll;
  logic [2:0] hw_req;
  logic [NUM_OUT*CNT_W-1:0] div_ratio;
  logic [NUM_OUT-1:0] clk_out;
  logic div_stall, sync_busy;

  int ncyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t expq[$];
  int ratios [NUM_OUT] = '{4, 5, 2};

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) ncyc <= ncyc + 1;

  odsync_ctrl #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .sw_sync(sw_sync),
    .hw_req(hw_req), .ref_edge(ref_edge), .fb_roll(fb_roll),
    .div_ratio(div_ratio), .clk_out(clk_out), .div_stall(div_stall),
    .sync_busy(sync_busy)
  );

  task automatic expect_at(input int cyc, input int sig, input logic val, input string tag);
    exp_t e;
    e.cyc = cyc; e.sig = sig; e.val = val; e.tag = tag;
    expq.push_back(e);
  endtask

  // monitor: pops due items and compares
  always @(negedge clk) begin
    for (int i = expq.size() - 1; i >= 0; i--) begin
      if (expq[i].cyc == ncyc) begin
        logic act;
        if (expq[i].sig == 0)      act = sync_busy;
        else if (expq[i].sig == 1) act = div_stall;
        else                       act = clk_out[expq[i].sig - 2];
        checks++;
        if (act !== expq[i].val) begin
          errors++;
          $display("FAIL %s cyc %0d sig %0d actual %b expected %b",
                   expq[i].tag, ncyc, expq[i].sig, act, expq[i].val);
        end
        expq.delete(i);
      end
    end
  end

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // input changed at negedge with count c: arm/stall expectations
  task automatic arm_checks(input int c, input string tag);
    expect_at(c + 2, 0, 1'b0, "R8");
    expect_at(c + 3, 0, 1'b1, {tag, " R11"});
    expect_at(c + 3, 1, 1'b0, "R8");
    expect_at(c + 4, 1, 1'b1, "R8");
    for (int i = 0; i < NUM_OUT; i++) expect_at(c + 4, 2 + i, 1'b0, "R9");
  endtask

  task automatic release_checks(input int c, input string tag);
    expect_at(c + 2, 0, 1'b1, "R8");
    expect_at(c + 3, 0, 1'b0, tag);
    expect_at(c + 3, 1, 1'b1, "R8");
    expect_at(c + 4, 1, 1'b0, tag);
    for (int i = 0; i < NUM_OUT; i++) begin
      expect_at(c + 4, 2 + i, 1'b0, "R9");
      expect_at(c + 3 + ratios[i], 2 + i, 1'b0, "R9");
      expect_at(c + 4 + ratios[i], 2 + i, 1'b1, "R9");
    end
  endtask

  task automatic pulse_evt(input bit use_fb);
    @(negedge clk);
    if (use_fb) fb_roll = 1'b1; else ref_edge = 1'b1;
    wait_cyc(2);
    fb_roll = 1'b0; ref_edge = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; mode_sel = 2'b00; sw_sync = 1'b0; hw_req = 3'b000;
    ref_edge = 1'b0; fb_roll = 1'b0;
    for (int i = 0; i < NUM_OUT; i++) div_ratio[i*CNT_W +: CNT_W] = CNT_W'(ratios[i]);
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    // R10 reset state
    expect_at(ncyc + 1, 0, 1'b0, "R10");
    expect_at(ncyc + 1, 1, 1'b0, "R10");
    drain();

    // R2 / R3: each hardware request alone, direct mode
    for (int j = 0; j < 3; j++) begin
      @(negedge clk); hw_req[j] = 1'b1; arm_checks(ncyc, "R2");
      drain(); wait_cyc(3);
      @(negedge clk); hw_req[j] = 1'b0; release_checks(ncyc, "R3");
      drain(); wait_cyc(2);
    end

    // R4: software bit; clearing is the event
    @(negedge clk); sw_sync = 1'b1; arm_checks(ncyc, "R2");
    drain(); wait_cyc(4);
    expect_at(ncyc + 1, 1, 1'b1, "R4");
    drain();
    @(negedge clk); sw_sync = 1'b0; release_checks(ncyc, "R4");
    drain(); wait_cyc(2);

    // R5 / R6: reference mode
    @(negedge clk); mode_sel = 2'b01; wait_cyc(4);
    @(negedge clk); hw_req[0] = 1'b1; arm_checks(ncyc, "R5");
    drain(); wait_cyc(2);
    @(negedge clk); hw_req[0] = 1'b0;
    expect_at(ncyc + 5, 0, 1'b1, "R5");
    expect_at(ncyc + 5, 1, 1'b1, "R5");
    drain();
    pulse_evt(1'b1);
    expect_at(ncyc + 5, 0, 1'b1, "R6");
    expect_at(ncyc + 5, 1, 1'b1, "R6");
    drain();
    @(negedge clk); ref_edge = 1'b1; release_checks(ncyc, "R6");
    wait_cyc(2); ref_edge = 1'b0;
    drain(); wait_cyc(2);

    // R7 / R6: feedback mode, re-arm attempts ignored
    @(negedge clk); mode_sel = 2'b10; wait_cyc(4);
    @(negedge clk); sw_sync = 1'b1; arm_checks(ncyc, "R5");
    drain();
    pulse_evt(1'b0);
    expect_at(ncyc + 5, 0, 1'b1, "R6");
    drain();
    @(negedge clk); sw_sync = 1'b0; wait_cyc(3);
    @(negedge clk); sw_sync = 1'b1;
    expect_at(ncyc + 6, 0, 1'b1, "R7");
    expect_at(ncyc + 6, 1, 1'b1, "R7");
    drain();
    @(negedge clk); fb_roll = 1'b1; release_checks(ncyc, "R6");
    wait_cyc(2); fb_roll = 1'b0;
    drain();
    wait_cyc(6);
    expect_at(ncyc + 1, 0, 1'b0, "R7");
    expect_at(ncyc + 1, 1, 1'b0, "R7");
    drain();
    @(negedge clk); sw_sync = 1'b0; wait_cyc(4);

    // R1: reserved code acts as direct
    @(negedge clk); mode_sel = 2'b11; wait_cyc(4);
    @(negedge clk); hw_req[2] = 1'b1; arm_checks(ncyc, "R1");
    drain(); wait_cyc(2);
    @(negedge clk); hw_req[2] = 1'b0; release_checks(ncyc, "R1");
    drain(); wait_cyc(2);

    // R10: reset while armed
    @(negedge clk); mode_sel = 2'b01; wait_cyc(4);
    @(negedge clk); hw_req[1] = 1'b1; arm_checks(ncyc, "R5");
    drain();
    @(negedge clk); hw_req[1] = 1'b0; rst_n = 1'b0;
    expect_at(ncyc + 1, 0, 1'b0, "R10");
    expect_at(ncyc + 1, 1, 1'b0, "R10");
    drain();
    @(negedge clk); rst_n = 1'b1; wait_cyc(4);
    pulse_evt(1'b0);
    expect_at(ncyc + 5, 0, 1'b0, "R10");
    expect_at(ncyc + 5, 1, 1'b0, "R10");
    drain();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule